// File: doc/BRIEF.md
# Four-Phase Cross-Clock Word Link

This block moves one data word at a time from a sender to a receiver that run on unrelated clocks. The two sides talk through a request line, an acknowledge line and a data bus. The handshake is return-to-zero and fully interlocked. The sender raises the request. The receiver takes in the word and raises the acknowledge. The sender then drops the request, and the receiver drops the acknowledge. Both lines must be low again before the next word can start.

Each control line entering a domain passes through a two-flop synchronizer before any logic reads it, and the unsynchronized line drives only the first flop. The data bus itself is not synchronized. It is bundled with the request: the sender loads it on the same edge that raises the request and keeps it unchanged until it sees the acknowledge. On the sender side a word is taken with a valid/ready pair. On the receiver side the word comes out with a one-cycle valid pulse. Each domain has its own reset, which asserts asynchronously and releases on that domain's clock.

Top module: `xclk_word_link`

## Requirements
- R1: Every word taken on a rising s_clk edge where s_valid and s_ready are both high appears exactly once on r_data, in the order it was taken, marked by r_valid. No other word appears.
- R2: The request rises only while the synchronized acknowledge is low, and falls only after that acknowledge has been seen high. The acknowledge rises only after the synchronized request has been seen high, and falls only after that request has been seen low.
- R3: The data bus does not change while the request is high and the sender has not yet seen the synchronized acknowledge. Changes on s_data while a transfer is in progress have no effect on the delivered word.
- R4: r_valid is high for exactly one r_clk cycle per delivered word, on the cycle the receiver captures the bus.
- R5: s_ready is low from the cycle after a word is taken until the sender has seen the synchronized acknowledge fall. While s_ready is low, s_valid is ignored.
- R6: While s_rst_n is low, s_ready is low. While r_rst_n is low, r_valid is low. Each reset release takes effect through a two-flop stage in its own clock domain, and s_ready goes high after the sender reset is released.
- R7: Each control line crossing between domains passes through exactly two flops in the destination domain. The acknowledge therefore cannot rise until the request has been high for at least two receiver edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sender clock |
| s_rst_n | input | 1 | Sender reset, active low, asynchronous assert |
| s_valid | input | 1 | Sender offers a word |
| s_data | input | DATA_W | Word offered by the sender |
| s_ready | output | 1 | Sender side can take a word |
| r_clk | input | 1 | Receiver clock |
| r_rst_n | input | 1 | Receiver reset, active low, asynchronous assert |
| r_data | output | DATA_W | Last word delivered |
| r_valid | output | 1 | One-cycle pulse marking a new word on r_data |

## Verification
Two sender-side events can land on the same edge. One is the end of the return-to-zero phase, when the synchronized acknowledge falls and s_ready rises. The other is a pending offer that has been held on s_valid throughout the busy period. The bench provokes this by keeping s_valid high with deliberately wrong data on s_data while a transfer runs, then switching to the next word. Any early or double acceptance would show up as a spurious or reordered word at the receiver. This is run against several receiver clock periods that are both faster and slower than the sender clock. Each delivered word is compared with a queue of the words the bench saw being accepted.

// File: rtl/xlink_pkg.sv
package xlink_pkg;

    // Sender handshake phases
    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_WAIT_ACK = 2'd1,
        TX_WAIT_RTZ = 2'd2
    } tx_state_e;

    // Receiver handshake phases
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_ACKED = 1'b1
    } rx_state_e;

    localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/xlink_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on the local clock
module xlink_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic [LAST:0] chain_d;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign rst_n = chain_q[LAST];
endmodule

// File: rtl/xlink_bit_sync.sv
// Level synchronizer: the foreign input feeds only the first flop
module xlink_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stage_q;
    logic [LAST:0] stage_d;

    always_comb begin
        stage_d = {stage_q[LAST-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/xlink_tx.sv
// Sender side: takes a word, raises request, waits ack high, then ack low
module xlink_tx
    import xlink_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              ack_sync,
    output logic              req,
    output logic [DATA_W-1:0] bus
);
    typedef struct packed {
        tx_state_e         state;
        logic              req;
        logic              ready;
        logic [DATA_W-1:0] bus;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            TX_IDLE: begin
                if (in_valid && q.ready) begin
                    d.bus   = in_data;
                    d.req   = 1'b1;
                    d.state = TX_WAIT_ACK;
                end
            end
            TX_WAIT_ACK: begin
                if (ack_sync) begin
                    d.req   = 1'b0;
                    d.state = TX_WAIT_RTZ;
                end
            end
            TX_WAIT_RTZ: begin
                if (!ack_sync) begin
                    d.state = TX_IDLE;
                end
            end
            default: begin
                d.req   = 1'b0;
                d.state = TX_IDLE;
            end
        endcase
        d.ready = (d.state == TX_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: TX_IDLE, req: 1'b0, ready: 1'b0, bus: '0};
        end else begin
            q <= d;
        end
    end

    assign in_ready = q.ready;
    assign req      = q.req;
    assign bus      = q.bus;
endmodule

// File: rtl/xlink_rx.sv
// Receiver side: captures the bus on synchronized request, acks, waits release
module xlink_rx
    import xlink_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] bus,
    output logic              ack,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    typedef struct packed {
        rx_state_e         state;
        logic              ack;
        logic              valid;
        logic [DATA_W-1:0] data;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.state)
            RX_IDLE: begin
                if (req_sync) begin
                    d.data  = bus;
                    d.valid = 1'b1;
                    d.ack   = 1'b1;
                    d.state = RX_ACKED;
                end
            end
            RX_ACKED: begin
                if (!req_sync) begin
                    d.ack   = 1'b0;
                    d.state = RX_IDLE;
                end
            end
            default: begin
                d.ack   = 1'b0;
                d.state = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: RX_IDLE, ack: 1'b0, valid: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign ack       = q.ack;
    assign out_data  = q.data;
    assign out_valid = q.valid;
endmodule

// File: rtl/xclk_word_link.sv
module xclk_word_link
    import xlink_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    input  logic              r_clk,
    input  logic              r_rst_n,
    output logic [DATA_W-1:0] r_data,
    output logic              r_valid
);
    logic              s_rst_loc_n;
    logic              r_rst_loc_n;
    logic              req;
    logic              ack;
    logic              req_s;
    logic              ack_s;
    logic [DATA_W-1:0] bus;

    xlink_rst_sync #(.STAGES(SYNC_DEPTH)) u_s_rst (
        .clk    (s_clk),
        .arst_n (s_rst_n),
        .rst_n  (s_rst_loc_n)
    );

    xlink_rst_sync #(.STAGES(SYNC_DEPTH)) u_r_rst (
        .clk    (r_clk),
        .arst_n (r_rst_n),
        .rst_n  (r_rst_loc_n)
    );

    xlink_bit_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk      (s_clk),
        .rst_n    (s_rst_loc_n),
        .async_in (ack),
        .sync_out (ack_s)
    );

    xlink_bit_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
        .clk      (r_clk),
        .rst_n    (r_rst_loc_n),
        .async_in (req),
        .sync_out (req_s)
    );

    xlink_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (s_clk),
        .rst_n    (s_rst_loc_n),
        .in_valid (s_valid),
        .in_data  (s_data),
        .in_ready (s_ready),
        .ack_sync (ack_s),
        .req      (req),
        .bus      (bus)
    );

    xlink_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (r_clk),
        .rst_n     (r_rst_loc_n),
        .req_sync  (req_s),
        .bus       (bus),
        .ack       (ack),
        .out_data  (r_data),
        .out_valid (r_valid)
    );
endmodule

// File: rtl/xlink_checker.sv
module xlink_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              s_clk,
    input logic              s_rst_n,
    input logic              r_clk,
    input logic              r_rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              req,
    input logic              ack,
    input logic              req_s,
    input logic              ack_s,
    input logic [DATA_W-1:0] bus,
    input logic              r_valid
);
    // R2: request edges follow the synchronized acknowledge
    p_req_rise_r2: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        $rose(req) |-> $past(!ack_s));
    p_req_fall_r2: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        $fell(req) |-> $past(ack_s));

    // R2: acknowledge edges follow the synchronized request
    p_ack_rise_r2: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        $rose(ack) |-> $past(req_s));
    p_ack_fall_r2: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        $fell(ack) |-> $past(!req_s));

    // R3: bundled data held while waiting for acknowledge
    p_bus_hold_r3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        ($past(req) && !$past(ack_s)) |-> $stable(bus));

    // R4: single-cycle valid pulse, coincident with the ack rising
    p_valid_pulse_r4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_valid |=> !r_valid);
    p_valid_with_ack_r4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_valid |-> $rose(ack));

    // R5: ready drops after a word is taken
    p_ready_drop_r5: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        (s_valid && s_ready) |=> !s_ready);

    // R7: two receiver edges of request before acknowledge
    p_sync_depth_r7: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        $rose(ack) |-> $past(req, 2));

    // R6: outputs quiet while the local reset is held
    always @(posedge s_clk) begin
        if (s_rst_n === 1'b0) begin
            p_ready_in_reset_r6: assert (!s_ready);
        end
    end
    always @(posedge r_clk) begin
        if (r_rst_n === 1'b0) begin
            p_valid_in_reset_r6: assert (!r_valid);
        end
    end
endmodule

bind xclk_word_link xlink_checker #(.DATA_W(DATA_W)) u_chk (
    .s_clk   (s_clk),
    .s_rst_n (s_rst_loc_n),
    .r_clk   (r_clk),
    .r_rst_n (r_rst_loc_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .req     (req),
    .ack     (ack),
    .req_s   (req_s),
    .ack_s   (ack_s),
    .bus     (bus),
    .r_valid (r_valid)
);

// File: tb/xclk_word_link_tb.sv
`timescale 1ns/1ps
module xclk_word_link_tb;
    localparam int W     = 8;
    localparam int WORDS = 64;
    localparam int CFGS  = 4;

    logic         s_clk = 1'b0;
    logic         r_clk = 1'b0;
    logic         s_rst_n = 1'b0;
    logic         r_rst_n = 1'b0;
    logic         s_valid = 1'b0;
    logic [W-1:0] s_data = '0;
    logic         s_ready;
    logic [W-1:0] r_data;
    logic         r_valid;

    int r_half = 7;
    int n_cmp  = 0;
    int n_bad  = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    logic         prev_v = 1'b0;
    logic [W-1:0] exp_q[$];

    always #10 s_clk = ~s_clk;
    always #(r_half) r_clk = ~r_clk;

    xclk_word_link #(.DATA_W(W)) u_dut (
        .s_clk   (s_clk),
        .s_rst_n (s_rst_n),
        .s_valid (s_valid),
        .s_data  (s_data),
        .s_ready (s_ready),
        .r_clk   (r_clk),
        .r_rst_n (r_rst_n),
        .r_data  (r_data),
        .r_valid (r_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] word_of(input int cfg, input int i);
        return W'(i * 29 + cfg * 71 + 5);
    endfunction

    function automatic int half_of(input int cfg);
        case (cfg)
            0: return 3;
            1: return 7;
            2: return 13;
            default: return 23;
        endcase
    endfunction

    // Receiver monitor, sampled on the falling edge
    always @(negedge r_clk) begin
        if (r_rst_n && r_valid) begin
            chk(!prev_v, "R4 pulse width", int'(prev_v), 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected word", int'(r_data), -1);
            end else begin
                // R1 order and R3 bundled data
                chk(r_data == exp_q[0], "R1/R3 word", int'(r_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
            rx_cnt++;
        end
        prev_v = r_valid;
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge s_clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", rx_cnt, tx_cnt);
        finish_run();
    end

    initial begin
        logic [W-1:0] w;
        #15;
        chk(s_ready == 1'b0, "R6 ready in reset", int'(s_ready), 0);
        chk(r_valid == 1'b0, "R6 valid in reset", int'(r_valid), 0);
        #85;
        s_rst_n = 1'b1;
        r_rst_n = 1'b1;
        repeat (5) @(negedge s_clk);
        chk(s_ready == 1'b1, "R6 ready after release", int'(s_ready), 1);

        for (int cfg = 0; cfg < CFGS; cfg++) begin
            r_half = half_of(cfg);
            @(negedge s_clk);
            for (int i = 0; i < WORDS; i++) begin
                w = word_of(cfg, i);
                s_valid = 1'b1;
                s_data  = w;
                while (!s_ready) @(negedge s_clk);
                exp_q.push_back(w);
                tx_cnt++;
                @(negedge s_clk);
                chk(s_ready == 1'b0, "R5 ready after take", int'(s_ready), 0);
                // R5/R3: wrong data offered while busy must be ignored
                s_data = ~w;
                @(negedge s_clk);
                if (i % 4 == 3) begin
                    s_valid = 1'b0;
                    repeat (3) @(negedge s_clk);
                end
            end
            s_valid = 1'b0;
            while (rx_cnt != tx_cnt) @(negedge s_clk);
            repeat (10) @(negedge s_clk);
        end

        chk(rx_cnt == CFGS * WORDS, "R1 delivered count", rx_cnt, CFGS * WORDS);
        chk(exp_q.size() == 0, "R1 leftover words", exp_q.size(), 0);

        @(negedge s_clk);
        s_rst_n = 1'b0;
        r_rst_n = 1'b0;
        #1;
        chk(s_ready == 1'b0, "R6 ready on reentry", int'(s_ready), 0);
        chk(r_valid == 1'b0, "R6 valid on reentry", int'(r_valid), 0);
        finish_run();
    end
endmodule